// File: doc/BRIEF.md
# Memory-Backed Pattern Sequencer

The sequencer plays a stored list of words onto a group of output pins, one word per sample period. Each word in the pattern memory is 32 bits wide, and only its low 20 bits reach the pins. A clock divider sets the sample period. The divider value is forced into a fixed legal window, which corresponds to a sample rate between roughly 252 kHz and 10 MHz at the system clock the defaults assume. The memory depth is `2**ADDR_W`. An `ADDR_W` of 16 gives 65,536 words. The default is kept small so that the block elaborates quickly.

Control follows three states: cleared, configured and playing. After a reset, the memory is overwritten with zeros at one address per clock, and configuration is refused until that sweep ends. A setup command latches the last valid address, the divider and the playback mode. The block has three playback modes:

- **Single-shot** plays the pattern once and then returns to the configured state.
- **Continuous** wraps to address 0 after the last word.
- **Step** advances one word per step command and never wraps.

The pins are driven only while the block is playing. A stop command releases them on the next clock edge.

Top module: `ptn_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `seq_state` is 0 (cleared), and `pin_oe`, `pin_data` and `done` are all zero.
- R2: After `rst_n` is released, or after `cmd_reset`, the block writes zero to every memory address, one address per clock. `cmd_setup` issued during this sweep leaves `seq_state` at 0. Once the sweep ends, every word plays back as zero.
- R3: `cmd_setup` is accepted only in state 0 after the sweep. It moves the block to state 1 (configured) and latches `cfg_last`, `cfg_div` and `cfg_mode`. The mode codes are 0 = single-shot, 1 = continuous and 2 = step. A `cmd_setup` issued in state 1 is ignored.
- R4: In state 2 (playing), `pin_oe` is all ones and `pin_data` equals bits [19:0] of the current word. In every other state, both outputs are zero.
- R5: The clock edge that accepts `cmd_run` loads word 0 onto the pins. Word k appears k·D clock cycles later, where D is the effective divider.
- R6: D equals `cfg_div` clamped to the range [`DIV_MIN`, `DIV_MAX`].
- R7: In single-shot mode, the word at `cfg_last` is held for D cycles. The block then returns to state 1, with `done` high for exactly one cycle.
- R8: In continuous mode, word 0 follows the word at `cfg_last`, and the block stays in state 2.
- R9: In step mode, `cmd_step` issued in state 1 enters state 2 with word 0 on the pins. Each later `cmd_step` advances one word. `done` pulses for one cycle when the word at `cfg_last` is loaded. Further steps keep that word. In step mode `cmd_run` is ignored, and in the other modes `cmd_step` is ignored.
- R10: `cmd_stop` in state 2 moves the block to state 1 on the next edge. Pins are released and `done` is not raised.
- R11: Memory writes take effect in states 0 and 1 once the sweep has ended. Writes issued in state 2 are ignored.
- R12: `cmd_reset` returns the block from any state to state 0 and restarts the zero sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_wr_en | input | 1 | Pattern memory write strobe |
| mem_wr_addr | input | ADDR_W | Write address |
| mem_wr_data | input | WORD_W | Write data word |
| cfg_last | input | ADDR_W | Address of the last pattern word, latched on setup |
| cfg_div | input | DIV_W | Clocks per sample, clamped and latched on setup |
| cfg_mode | input | 2 | Playback mode: 0 single-shot, 1 continuous, 2 step |
| cmd_setup | input | 1 | Latch configuration |
| cmd_run | input | 1 | Start single-shot or continuous playback |
| cmd_step | input | 1 | Enter or advance step playback |
| cmd_stop | input | 1 | Halt playback and release the pins |
| cmd_reset | input | 1 | Clear configuration and zero the memory |
| pin_data | output | PIN_W | Pin output values |
| pin_oe | output | PIN_W | Pin output enables |
| done | output | 1 | One-cycle end-of-pattern pulse |
| seq_state | output | 2 | Control state: 0 cleared, 1 configured, 2 playing |

## Verification
The assertions assume that at most one command strobe is high in any cycle. They also assume that `DIV_MIN` is at least 2, so that two sample ticks are never adjacent. The bench keeps to both conditions: every command passes through a single task that raises exactly one strobe for one cycle, and only the default divider bounds are used. Memory writes are issued from separate tasks and never overlap a command, except for the write that is deliberately placed inside a single-shot run to show that it is ignored.

// File: rtl/ptn_pkg.sv
// Shared encodings for the pattern sequencer.
// Assumes: state and mode codes are visible at the top-level ports as-is.
package ptn_pkg;
    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_READY = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        MD_ONCE = 2'd0,
        MD_LOOP = 2'd1,
        MD_STEP = 2'd2,
        MD_NONE = 2'd3
    } play_mode_e;
endpackage

// File: rtl/ptn_rate_div.sv
// Sample-rate divider. It holds the clamped divider latched on setup and
// emits a one-cycle tick every div_q clocks while playback runs freely.
// Assumes: DIV_MIN >= 2. A restart places the count one past the tick,
// because the run edge itself has already consumed word 0.
module ptn_rate_div #(
    parameter int DIV_W   = 16,
    parameter int DIV_MIN = 10,
    parameter int DIV_MAX = 396
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic             restart,
    input  logic             active,
    output logic             tick
);
    localparam logic [DIV_W-1:0] LO = DIV_W'(DIV_MIN);
    localparam logic [DIV_W-1:0] HI = DIV_W'(DIV_MAX);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    // Latch the divider on setup, forced into the legal window.
    always_ff @(posedge clk) begin
        if (!rst_n)              div_q <= LO;
        else if (load) begin
            if (div_in < LO)      div_q <= LO;
            else if (div_in > HI) div_q <= HI;
            else                  div_q <= div_in;
        end
    end

    // Count clocks within one sample period.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= DIV_W'(1);
        else if (active)  cnt_q <= (cnt_q == div_q - 1'b1) ? '0 : cnt_q + 1'b1;
    end

    assign tick = active && (cnt_q == '0);

    // R5
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/ptn_store.sv
// Pattern memory with a zero sweep after reset, and a registered read whose
// output register doubles as the pin value register.
// Assumes: the controller issues no read while the sweep is busy.
module ptn_store #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 32,
    parameter int PIN_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_ok,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PIN_W-1:0]  rd_q,
    output logic              sweep_busy
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] sw_addr;

    // Walk every address once after any reset request.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sweep_busy <= 1'b1;
            sw_addr    <= '0;
        end else if (sweep_busy) begin
            sw_addr <= sw_addr + 1'b1;
            if (sw_addr == TOP_ADDR) sweep_busy <= 1'b0;
        end
    end

    // Single write port: sweep zeros first, user words otherwise.
    always_ff @(posedge clk) begin
        if (sweep_busy)            mem[sw_addr] <= '0;
        else if (wr_en && wr_ok)   mem[wr_addr] <= wr_data;
    end

    // Registered read of the pin-facing low bits.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= mem[rd_addr][PIN_W-1:0];
    end

    // R2
    sweep_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_busy |-> !rd_en);
endmodule

// File: rtl/ptn_ctrl.sv
// Control state machine: setup, run, step, stop and reset handling, the
// playback address, and end-of-pattern detection for the three modes.
// Assumes: at most one command strobe is high per cycle.
module ptn_ctrl
    import ptn_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_setup,
    input  logic              cmd_run,
    input  logic              cmd_step,
    input  logic              cmd_stop,
    input  logic              cmd_reset,
    input  logic [ADDR_W-1:0] cfg_last,
    input  logic [1:0]        cfg_mode,
    input  logic              sweep_busy,
    input  logic              tick,
    output seq_state_e        st,
    output logic              div_load,
    output logic              div_restart,
    output logic              div_active,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_ok,
    output logic              done
);
    play_mode_e        mode_q;
    logic [ADDR_W-1:0] last_q;
    logic [ADDR_W-1:0] addr_q;
    logic              at_last;
    logic              setup_ok, start_run, start_step, start;
    logic              free_run, adv_tick, adv_step, finish, hold;

    // Decode the accepted action for this cycle.
    always_comb begin
        hold       = cmd_reset || cmd_stop;
        setup_ok   = (st == ST_RESET) && !sweep_busy && cmd_setup && !hold;
        start_run  = (st == ST_READY) && cmd_run && !hold &&
                     (mode_q == MD_ONCE || mode_q == MD_LOOP);
        start_step = (st == ST_READY) && cmd_step && !hold && (mode_q == MD_STEP);
        start      = start_run || start_step;
        free_run   = (st == ST_RUN) && (mode_q != MD_STEP);
        adv_tick   = free_run && tick && !hold && !(mode_q == MD_ONCE && at_last);
        finish     = free_run && tick && !hold && (mode_q == MD_ONCE) && at_last;
        adv_step   = (st == ST_RUN) && (mode_q == MD_STEP) && cmd_step && !hold && !at_last;
    end

    assign rd_en       = start || adv_tick || adv_step;
    assign rd_addr     = start ? '0 : addr_q;
    assign div_load    = setup_ok;
    assign div_restart = start;
    assign div_active  = free_run;
    assign wr_ok       = (st != ST_RUN);

    // Advance the state, address and end flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_RESET;
            mode_q  <= MD_ONCE;
            last_q  <= '0;
            addr_q  <= '0;
            at_last <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (cmd_reset) begin
                st <= ST_RESET;
            end else if (cmd_stop && st == ST_RUN) begin
                st <= ST_READY;
            end else if (setup_ok) begin
                st     <= ST_READY;
                mode_q <= play_mode_e'(cfg_mode);
                last_q <= cfg_last;
            end else if (start) begin
                st      <= ST_RUN;
                addr_q  <= (last_q == '0) ? '0 : ADDR_W'(1);
                at_last <= (last_q == '0);
                done    <= start_step && (last_q == '0);
            end else if (adv_tick || adv_step) begin
                addr_q  <= (addr_q == last_q) ? '0 : addr_q + 1'b1;
                at_last <= (addr_q == last_q);
                done    <= adv_step && (addr_q == last_q);
            end else if (finish) begin
                st   <= ST_READY;
                done <= 1'b1;
            end
        end
    end

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && cmd_stop && !cmd_reset) |=> (st == ST_READY));
    // R2
    setup_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RESET && sweep_busy) |=> (st == ST_RESET));
    // R8
    loop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && mode_q == MD_LOOP) |-> (addr_q <= last_q));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && mode_q == MD_STEP && at_last && !cmd_reset && !cmd_stop)
        |=> (st == ST_RUN && at_last));
endmodule

// File: rtl/ptn_seq.sv
// Top level of the pattern sequencer. It joins the controller, the divider
// and the memory, and gates the pins so that they are driven only while
// the block is playing.
// Assumes: PIN_W <= WORD_W and DIV_MIN >= 2; ADDR_W of up to 16 is intended.
module ptn_seq
    import ptn_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int WORD_W  = 32,
    parameter int PIN_W   = 20,
    parameter int DIV_W   = 16,
    parameter int DIV_MIN = 10,
    parameter int DIV_MAX = 396
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_wr_en,
    input  logic [ADDR_W-1:0] mem_wr_addr,
    input  logic [WORD_W-1:0] mem_wr_data,
    input  logic [ADDR_W-1:0] cfg_last,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [1:0]        cfg_mode,
    input  logic              cmd_setup,
    input  logic              cmd_run,
    input  logic              cmd_step,
    input  logic              cmd_stop,
    input  logic              cmd_reset,
    output logic [PIN_W-1:0]  pin_data,
    output logic [PIN_W-1:0]  pin_oe,
    output logic              done,
    output logic [1:0]        seq_state
);
    seq_state_e        st;
    logic              div_load, div_restart, div_active, tick;
    logic              rd_en, wr_ok, sweep_busy;
    logic [ADDR_W-1:0] rd_addr;
    logic [PIN_W-1:0]  rd_q;
    logic              playing;

    ptn_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_setup(cmd_setup), .cmd_run(cmd_run), .cmd_step(cmd_step),
        .cmd_stop(cmd_stop), .cmd_reset(cmd_reset),
        .cfg_last(cfg_last), .cfg_mode(cfg_mode),
        .sweep_busy(sweep_busy), .tick(tick),
        .st(st), .div_load(div_load), .div_restart(div_restart),
        .div_active(div_active), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_ok(wr_ok), .done(done)
    );

    ptn_rate_div #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)) u_div (
        .clk(clk), .rst_n(rst_n), .load(div_load), .div_in(cfg_div),
        .restart(div_restart), .active(div_active), .tick(tick)
    );

    ptn_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PIN_W(PIN_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(cmd_reset),
        .wr_en(mem_wr_en), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data),
        .wr_ok(wr_ok), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_q(rd_q), .sweep_busy(sweep_busy)
    );

    // Drive the pins only while playing.
    always_comb begin
        playing   = (st == ST_RUN);
        pin_oe    = {PIN_W{playing}};
        pin_data  = playing ? rd_q : '0;
        seq_state = st;
    end
endmodule

// File: tb/test_ptn_seq.sv
`timescale 1ns/1ps
module test_ptn_seq;
    localparam int AW = 8, WW = 32, PW = 20, DW = 16;
    localparam int DMIN = 10, DMAX = 396;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_wr_en = 1'b0;
    logic [AW-1:0] mem_wr_addr = '0;
    logic [WW-1:0] mem_wr_data = '0;
    logic [AW-1:0] cfg_last = '0;
    logic [DW-1:0] cfg_div = '0;
    logic [1:0]    cfg_mode = '0;
    logic          cmd_setup = 1'b0, cmd_run = 1'b0, cmd_step = 1'b0;
    logic          cmd_stop = 1'b0, cmd_reset = 1'b0;
    logic [PW-1:0] pin_data, pin_oe;
    logic          done;
    logic [1:0]    seq_state;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    ptn_seq #(.ADDR_W(AW), .WORD_W(WW), .PIN_W(PW), .DIV_W(DW),
              .DIV_MIN(DMIN), .DIV_MAX(DMAX)) i_ptn_seq (
        .clk(clk), .rst_n(rst_n), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .cfg_last(cfg_last), .cfg_div(cfg_div),
        .cfg_mode(cfg_mode), .cmd_setup(cmd_setup), .cmd_run(cmd_run),
        .cmd_step(cmd_step), .cmd_stop(cmd_stop), .cmd_reset(cmd_reset),
        .pin_data(pin_data), .pin_oe(pin_oe), .done(done), .seq_state(seq_state)
    );

    function automatic logic [WW-1:0] pat(input int i);
        pat = {12'hC3A ^ 12'(i), 20'(i * 32'h0001_3579 + 32'h0000_04F1)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bits: {reset, stop, step, run, setup}
    task automatic cmd(input logic [4:0] v);
        @(negedge clk);
        {cmd_reset, cmd_stop, cmd_step, cmd_run, cmd_setup} = v;
        @(negedge clk);
        {cmd_reset, cmd_stop, cmd_step, cmd_run, cmd_setup} = '0;
    endtask

    task automatic setup(input int last, input int div, input int mode);
        cfg_last = AW'(last); cfg_div = DW'(div); cfg_mode = 2'(mode);
        cmd(5'b00001);
    endtask

    task automatic write_word(input int a, input logic [WW-1:0] d);
        @(negedge clk);
        mem_wr_en = 1'b1; mem_wr_addr = AW'(a); mem_wr_data = d;
        @(negedge clk);
        mem_wr_en = 1'b0;
    endtask

    task automatic load_pattern(input int n);
        for (int i = 0; i < n; i++) write_word(i, pat(i));
    endtask

    task automatic clear_all();
        cmd(5'b10000);
        check("R12 state after reset cmd", 32'(seq_state), 32'd0);
        repeat (DEPTH + 4) @(negedge clk);
    endtask

    task automatic t_reset_state();
        repeat (3) @(negedge clk);
        check("R1 state in reset", 32'(seq_state), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 state", 32'(seq_state), 32'd0);
        check("R1 oe", 32'(pin_oe), 32'd0);
        check("R1 data", 32'(pin_data), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        setup(3, 20, 0);
        check("R2 setup during sweep refused", 32'(seq_state), 32'd0);
        repeat (DEPTH + 4) @(negedge clk);
    endtask

    task automatic t_zero_fill();
        load_pattern(4);
        clear_all();
        setup(3, 20, 0);
        check("R3 setup accepted", 32'(seq_state), 32'd1);
        setup(1, 20, 1);
        check("R3 setup in ready ignored", 32'(seq_state), 32'd1);
        cmd(5'b00010);
        for (int k = 0; k < 4; k++) begin
            check("R2 zero word", 32'(pin_data), 32'd0);
            repeat (20) @(negedge clk);
        end
        check("R3 original single-shot kept", 32'(seq_state), 32'd1);
        check("R7 done after once", 32'(done), 32'd1);
    endtask

    task automatic t_once();
        clear_all();
        load_pattern(4);
        setup(3, 3, 0);
        cmd(5'b00100);
        check("R9 step ignored in single-shot", 32'(seq_state), 32'd1);
        cmd(5'b00010);
        check("R4 state playing", 32'(seq_state), 32'd2);
        check("R4 oe all ones", 32'(pin_oe), 32'hFFFFF);
        for (int k = 0; k < 4; k++) begin
            check("R5 word on pins", 32'(pin_data), 32'(pat(k)) & 32'hFFFFF);
            if (k == 0) begin
                write_word(2, 32'h0);
                repeat (DMIN - 3) @(negedge clk);
            end else begin
                repeat (DMIN - 1) @(negedge clk);
            end
            check("R6 low clamp held", 32'(pin_data), 32'(pat(k)) & 32'hFFFFF);
            @(negedge clk);
        end
        check("R7 back to ready", 32'(seq_state), 32'd1);
        check("R7 done high", 32'(done), 32'd1);
        check("R4 oe off", 32'(pin_oe), 32'd0);
        check("R4 data off", 32'(pin_data), 32'd0);
        @(negedge clk);
        check("R7 done one cycle", 32'(done), 32'd0);
        cmd(5'b00010);
        repeat (2 * DMIN) @(negedge clk);
        check("R11 write during run ignored", 32'(pin_data), 32'(pat(2)) & 32'hFFFFF);
        cmd(5'b01000);
    endtask

    task automatic t_loop();
        clear_all();
        load_pattern(3);
        setup(2, 16'hFFFF, 1);
        cmd(5'b00010);
        for (int k = 0; k < 4; k++) begin
            check("R8 loop word", 32'(pin_data), 32'(pat(k % 3)) & 32'hFFFFF);
            repeat (DMAX - 1) @(negedge clk);
            check("R6 high clamp held", 32'(pin_data), 32'(pat(k % 3)) & 32'hFFFFF);
            @(negedge clk);
        end
        check("R8 still playing", 32'(seq_state), 32'd2);
        cmd(5'b01000);
        check("R10 state ready", 32'(seq_state), 32'd1);
        check("R10 oe off", 32'(pin_oe), 32'd0);
        check("R10 no done", 32'(done), 32'd0);
    endtask

    task automatic t_step();
        clear_all();
        load_pattern(3);
        setup(2, 10, 2);
        cmd(5'b00010);
        check("R9 run ignored in step mode", 32'(seq_state), 32'd1);
        for (int k = 0; k < 3; k++) begin
            cmd(5'b00100);
            check("R9 step state", 32'(seq_state), 32'd2);
            check("R9 step word", 32'(pin_data), 32'(pat(k)) & 32'hFFFFF);
            check("R9 step done", 32'(done), (k == 2) ? 32'd1 : 32'd0);
        end
        cmd(5'b00100);
        check("R9 no wrap", 32'(pin_data), 32'(pat(2)) & 32'hFFFFF);
        check("R9 done once", 32'(done), 32'd0);
        repeat (50) @(negedge clk);
        check("R9 holds without steps", 32'(pin_data), 32'(pat(2)) & 32'hFFFFF);
        cmd(5'b01000);
        check("R10 stop from step", 32'(seq_state), 32'd1);
    endtask

    initial begin
        t_reset_state();
        t_zero_fill();
        t_once();
        t_loop();
        t_step();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule